// File: doc/BRIEF.md
# CAN Controller Host Register Interface

This block is the byte-wide register file that a host processor sees on a CAN controller running its extended register set. It holds the mode byte, a command byte that can only be written, the status byte, an interrupt byte that clears when it is read, and an interrupt enable byte. It also holds the acceptance code and mask bytes and the transmit frame buffer. One level-sensitive interrupt line leaves the block.

Addresses 16 to 28 form one shared window, and the reset-mode bit of the mode byte decides where it points. While that bit is set, the window reaches the eight acceptance bytes. While it is clear, the window reaches the thirteen transmit buffer bytes. When the controller leaves reset mode, the acceptance bytes and the single/dual filter choice are copied into a filter set that the frame acceptance logic reads.

The bus side is abstracted. A transmit request becomes a one-cycle `tx_start` strobe. The receive path reports itself through three strobes: reception started, a message was stored, and a message was lost to overrun. The block counts stored messages that the host has not yet released.

Top module: `can_host_regs`

## Requirements
- R1: After hardware reset the mode byte (address 0) reads 0x01, the status byte (address 2) reads 0x0C, the interrupt byte (address 3) and the enable byte (address 4) read 0x00, and `irq` is low.
- R2: A write to address 0 stores only bits 4:0 of the data. Bit 0 is the reset-mode bit and bit 3 selects single filter mode.
- R3: A read of address 1 returns 0x00. Writes to address 2 and address 3 leave the status and interrupt bytes unchanged.
- R4: In reset mode, writes to addresses 16 to 23 store acceptance byte (address-16), and reads there return that byte. Addresses 24 to 28 store nothing and read 0x00. Any write from 16 to 28 sets status bit 5.
- R5: In operating mode, a write to address 16+k stores transmit byte k on `tx_frame[8k+7:8k]`, a read there returns it, and the acceptance bytes do not change.
- R6: Writing command bit 0 pulses `tx_start` for exactly the one cycle after the write. It also leaves status bits 2 and 3 set and bit 5 clear, and sets interrupt bit 1.
- R7: When mode bit 0 goes from 1 to 0, `filt_code` takes acceptance bytes 0..3 (byte 0 in bits 7:0), `filt_mask` takes bytes 4..7, and `filt_single` takes the new mode bit 3. These outputs hold while the block stays in operating mode.
- R8: In operating mode, `rx_start` sets status bit 4. `rx_store` adds one pending message, sets status bit 0 and interrupt bit 0, and clears status bit 4. In reset mode, all three receive strobes are ignored.
- R9: Command bit 2 releases one pending message. When none remain, status bit 0 and interrupt bit 0 clear. Status bit 0 is set exactly when messages are pending.
- R10: `rx_overrun` in operating mode sets status bit 1 and interrupt bit 3. Command bit 3 clears both.
- R11: A read of address 3 returns the interrupt byte and clears it. Bit 0 is set again if messages remain pending.
- R12: `irq` is high exactly when the enable byte ANDed with the interrupt byte is nonzero.
- R13: A mode write that sets bit 0 while it was clear is a software reset. It clears status bits 0 and 1, sets bits 2, 4 and 5, leaves bit 3, and discards all pending messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (interrupt byte clears at the edge) |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_start | input | 1 | Receive path began a frame |
| rx_store | input | 1 | Receive path stored a message |
| rx_overrun | input | 1 | Receive path lost a message |
| tx_start | output | 1 | One-cycle request to send the transmit buffer |
| tx_frame | output | 104 | Transmit buffer, byte k at bits 8k+7:8k |
| filt_single | output | 1 | Latched single-filter selection |
| filt_code | output | 32 | Latched acceptance code bytes |
| filt_mask | output | 32 | Latched acceptance mask bytes |
| irq | output | 1 | Level interrupt line |

## Verification
Three things are checked on every cycle by assertions. Status bit 0 always matches a nonzero pending count. A `tx_start` strobe always arrives with the completed-transmit status and interrupt bits. The acceptance bytes, the latched filters and the pending count stay frozen in the mode where they must not move. Other behaviour needs the directed scenarios to show it, because it depends on the host's sequence of reads and writes. This covers the address window switching with the mode bit, the interrupt byte coming back after a clear-on-read while messages remain, the exact status values after a software reset, and the interrupt line following changes to the enable byte.

// File: rtl/can_hostif_pkg.sv
package can_hostif_pkg;
  // Host register addresses
  localparam int unsigned A_MODE = 0;
  localparam int unsigned A_CMD  = 1;
  localparam int unsigned A_STAT = 2;
  localparam int unsigned A_IRQ  = 3;
  localparam int unsigned A_IEN  = 4;

  // Mode bits
  localparam int unsigned MD_RESET  = 0;
  localparam int unsigned MD_SINGLE = 3;
  localparam int unsigned MD_BITS   = 5;

  // Command bits
  localparam int unsigned CM_SEND   = 0;
  localparam int unsigned CM_FREE   = 2;
  localparam int unsigned CM_CLROVR = 3;

  // Status bits
  localparam int unsigned SB_RXFULL = 0;
  localparam int unsigned SB_OVR    = 1;
  localparam int unsigned SB_TXFREE = 2;
  localparam int unsigned SB_TXDONE = 3;
  localparam int unsigned SB_RXBUSY = 4;
  localparam int unsigned SB_TXBUSY = 5;
  localparam int unsigned SB_BITS   = 6;

  // Interrupt bits
  localparam int unsigned IB_RX  = 0;
  localparam int unsigned IB_TX  = 1;
  localparam int unsigned IB_OVR = 3;

  localparam logic [SB_BITS-1:0] ST_HW_INIT = 6'h0C;
  localparam logic [SB_BITS-1:0] ST_SW_CLR  = 6'h37;
  localparam logic [SB_BITS-1:0] ST_SW_SET  = 6'h34;

  typedef struct packed {
    logic mode;
    logic cmd;
    logic stat;
    logic irq;
    logic ien;
    logic win;
  } reg_hit_t;
endpackage

// File: rtl/can_hostif_decode.sv
module can_hostif_decode
  import can_hostif_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BASE  = 16,
  parameter int WIN_BYTES = 13,
  localparam int IDX_W    = $clog2(WIN_BYTES)
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_hit_t          hit,
  output logic [IDX_W-1:0]  win_idx
);
  logic [ADDR_W-1:0] win_off;
  int unsigned       addr_i;

  always_comb begin
    addr_i   = int'(bus_addr);
    hit      = '0;
    hit.mode = (addr_i == A_MODE);
    hit.cmd  = (addr_i == A_CMD);
    hit.stat = (addr_i == A_STAT);
    hit.irq  = (addr_i == A_IRQ);
    hit.ien  = (addr_i == A_IEN);
    hit.win  = (addr_i >= WIN_BASE) && (addr_i < WIN_BASE + WIN_BYTES);
  end

  assign win_off = bus_addr - ADDR_W'(WIN_BASE);
  assign win_idx = win_off[IDX_W-1:0];
endmodule

// File: rtl/can_hostif_status.sv
module can_hostif_status
  import can_hostif_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_mode,
  input  logic       sw_reset,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic       irq_rd,
  input  logic       win_wr,
  input  logic [7:0] ien,
  input  logic       rx_start,
  input  logic       rx_store,
  input  logic       rx_overrun,
  output logic [7:0] status,
  output logic [7:0] irq_reg,
  output logic       irq,
  output logic       tx_start
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SB_BITS-1:0] st_q, st_d;
  logic [7:0]         ir_q, ir_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               tx_q, tx_d;
  logic               upd_en;

  assign upd_en = cmd_wr | irq_rd | win_wr | sw_reset |
                  rx_start | rx_store | rx_overrun;

  always_comb begin
    st_d  = st_q;
    ir_d  = ir_q;
    cnt_d = cnt_q;
    tx_d  = 1'b0;
    if (irq_rd) ir_d = '0;
    if (win_wr) st_d[SB_TXBUSY] = 1'b1;
    if (cmd_wr) begin
      if (cmd_data[CM_SEND]) begin
        st_d[SB_TXFREE] = 1'b1;
        st_d[SB_TXDONE] = 1'b1;
        st_d[SB_TXBUSY] = 1'b0;
        ir_d[IB_TX]     = 1'b1;
        tx_d            = 1'b1;
      end
      if (cmd_data[CM_FREE] && (cnt_q != '0)) begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_d == '0) begin
          st_d[SB_RXFULL] = 1'b0;
          ir_d[IB_RX]     = 1'b0;
        end
      end
      if (cmd_data[CM_CLROVR]) begin
        st_d[SB_OVR] = 1'b0;
        ir_d[IB_OVR] = 1'b0;
      end
    end
    if (op_mode) begin
      if (rx_start) st_d[SB_RXBUSY] = 1'b1;
      if (rx_store) begin
        if (cnt_d != CNT_MAX) cnt_d = cnt_d + 1'b1;
        st_d[SB_RXFULL] = 1'b1;
        st_d[SB_RXBUSY] = 1'b0;
        ir_d[IB_RX]     = 1'b1;
      end
      if (rx_overrun) begin
        st_d[SB_OVR]    = 1'b1;
        st_d[SB_RXBUSY] = 1'b0;
        ir_d[IB_OVR]    = 1'b1;
      end
    end
    if (sw_reset) begin
      st_d  = (st_d & ~ST_SW_CLR) | ST_SW_SET;
      cnt_d = '0;
    end
    if (irq_rd && (cnt_d != '0)) ir_d[IB_RX] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HW_INIT;
      ir_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      ir_q  <= ir_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_d;
  end

  assign status   = {{(8-SB_BITS){1'b0}}, st_q};
  assign irq_reg  = ir_q;
  assign irq      = |(ien & ir_q);
  assign tx_start = tx_q;

  AST_RXFULL_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[SB_RXFULL] == (cnt_q != '0)); // R9
  AST_TX_STROBE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q |-> (st_q[SB_TXFREE] && st_q[SB_TXDONE] && !st_q[SB_TXBUSY] && ir_q[IB_TX])); // R6
  AST_RESET_MODE_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_mode && !cmd_wr) |=> (cnt_q == $past(cnt_q))); // R8
  AST_IRQ_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd |=> !ir_q[IB_TX]); // R11
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != '0)); // R12
endmodule

// File: rtl/can_hostif_window.sv
module can_hostif_window #(
  parameter int WIN_BYTES = 13,
  parameter int ACC_BYTES = 8,
  localparam int IDX_W    = $clog2(WIN_BYTES),
  localparam int AIDX_W   = $clog2(ACC_BYTES),
  localparam int HALF     = ACC_BYTES / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rst_mode,
  input  logic                   win_wr,
  input  logic [IDX_W-1:0]       win_idx,
  input  logic [7:0]             wdata,
  input  logic                   latch,
  output logic [7:0]             win_rdata,
  output logic [WIN_BYTES*8-1:0] tx_frame,
  output logic [HALF*8-1:0]      filt_code,
  output logic [HALF*8-1:0]      filt_mask
);
  logic [7:0] acc_q  [ACC_BYTES];
  logic [7:0] tx_q   [WIN_BYTES];
  logic [7:0] filt_q [ACC_BYTES];
  logic       in_acc;

  assign in_acc = int'(win_idx) < ACC_BYTES;

  for (genvar b = 0; b < ACC_BYTES; b++) begin : g_acc
    logic acc_en;
    assign acc_en = win_wr && rst_mode && (int'(win_idx) == b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q[b] <= '0;
      else if (acc_en) acc_q[b] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     filt_q[b] <= '0;
      else if (latch) filt_q[b] <= acc_q[b];
    end
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_tx
    logic tx_en;
    assign tx_en = win_wr && !rst_mode && (int'(win_idx) == b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tx_q[b] <= '0;
      else if (tx_en) tx_q[b] <= wdata;
    end
    assign tx_frame[b*8 +: 8] = tx_q[b];
  end

  for (genvar b = 0; b < HALF; b++) begin : g_filt
    assign filt_code[b*8 +: 8] = filt_q[b];
    assign filt_mask[b*8 +: 8] = filt_q[HALF+b];
  end

  always_comb begin
    win_rdata = '0;
    if (rst_mode) begin
      if (in_acc) win_rdata = acc_q[win_idx[AIDX_W-1:0]];
    end else if (int'(win_idx) < WIN_BYTES) begin
      win_rdata = tx_q[win_idx];
    end
  end

  AST_FILTERS_HOLD_IN_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_mode |=> ($stable(filt_code) && $stable(filt_mask))); // R7
  AST_ACCEPT_BYTES_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_mode |=> ($stable(acc_q[0]) && $stable(acc_q[ACC_BYTES-1]))); // R5
endmodule

// File: rtl/can_host_regs.sv
module can_host_regs
  import can_hostif_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BASE  = 16,
  parameter int WIN_BYTES = 13,
  parameter int ACC_BYTES = 8,
  parameter int CNT_W     = 6,
  localparam int IDX_W    = $clog2(WIN_BYTES),
  localparam int HALF     = ACC_BYTES / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic                   rx_start,
  input  logic                   rx_store,
  input  logic                   rx_overrun,
  output logic                   tx_start,
  output logic [WIN_BYTES*8-1:0] tx_frame,
  output logic                   filt_single,
  output logic [HALF*8-1:0]      filt_code,
  output logic [HALF*8-1:0]      filt_mask,
  output logic                   irq
);
  reg_hit_t           hit;
  logic [IDX_W-1:0]   win_idx;
  logic [MD_BITS-1:0] mode_q, mode_d;
  logic [7:0]         ien_q, ien_d;
  logic               mode_en, ien_en;
  logic               sw_reset, latch;
  logic [7:0]         status, irq_reg, win_rdata;

  can_hostif_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) decode_i (
    .bus_addr(bus_addr), .hit(hit), .win_idx(win_idx)
  );

  assign mode_en  = bus_wr && hit.mode;
  assign ien_en   = bus_wr && hit.ien;
  assign mode_d   = bus_wdata[MD_BITS-1:0];
  assign ien_d    = bus_wdata;
  assign sw_reset = mode_en && !mode_q[MD_RESET] && bus_wdata[MD_RESET];
  assign latch    = mode_en && mode_q[MD_RESET] && !bus_wdata[MD_RESET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MD_BITS'(1);
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     filt_single <= 1'b0;
    else if (latch) filt_single <= bus_wdata[MD_SINGLE];
  end

  can_hostif_status #(.CNT_W(CNT_W)) status_i (
    .clk(clk), .rst_n(rst_n),
    .op_mode(!mode_q[MD_RESET]), .sw_reset(sw_reset),
    .cmd_wr(bus_wr && hit.cmd), .cmd_data(bus_wdata),
    .irq_rd(bus_rd && hit.irq), .win_wr(bus_wr && hit.win),
    .ien(ien_q),
    .rx_start(rx_start), .rx_store(rx_store), .rx_overrun(rx_overrun),
    .status(status), .irq_reg(irq_reg), .irq(irq), .tx_start(tx_start)
  );

  can_hostif_window #(.WIN_BYTES(WIN_BYTES), .ACC_BYTES(ACC_BYTES)) window_i (
    .clk(clk), .rst_n(rst_n),
    .rst_mode(mode_q[MD_RESET]),
    .win_wr(bus_wr && hit.win), .win_idx(win_idx), .wdata(bus_wdata),
    .latch(latch), .win_rdata(win_rdata),
    .tx_frame(tx_frame), .filt_code(filt_code), .filt_mask(filt_mask)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (1'b1)
        hit.mode: bus_rdata = {{(8-MD_BITS){1'b0}}, mode_q};
        hit.stat: bus_rdata = status;
        hit.irq:  bus_rdata = irq_reg;
        hit.ien:  bus_rdata = ien_q;
        hit.win:  bus_rdata = win_rdata;
        default:  bus_rdata = '0;
      endcase
    end
  end

  AST_MODE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit.mode) |-> (bus_rdata[7:MD_BITS] == '0)); // R2
  AST_LATCH_LEAVES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !mode_q[MD_RESET]); // R7
endmodule

// File: tb/can_host_regs_tb.sv
module can_host_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         rx_start = 1'b0, rx_store = 1'b0, rx_overrun = 1'b0;
  logic         tx_start, filt_single, irq;
  logic [103:0] tx_frame;
  logic [31:0]  filt_code, filt_mask;
  int           errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  can_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_start(rx_start), .rx_store(rx_store), .rx_overrun(rx_overrun),
    .tx_start(tx_start), .tx_frame(tx_frame), .filt_single(filt_single),
    .filt_code(filt_code), .filt_mask(filt_mask), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic pulse_rx(input int kind);
    @(negedge clk);
    rx_start = (kind == 0); rx_store = (kind == 1); rx_overrun = (kind == 2);
    @(negedge clk);
    rx_start = 1'b0; rx_store = 1'b0; rx_overrun = 1'b0;
  endtask

  task automatic t_reset_state();
    rd_chk("R1 mode", 5'd0, 8'h01);
    rd_chk("R1 status", 5'd2, 8'h0C);
    rd_chk("R1 irq reg", 5'd3, 8'h00);
    rd_chk("R1 enable", 5'd4, 8'h00);
    chk("R1 irq line", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mode_bits();
    wr(5'd0, 8'hE9);
    rd_chk("R2 mode masked", 5'd0, 8'h09);
  endtask

  task automatic t_ro_regs();
    rd_chk("R3 cmd reads zero", 5'd1, 8'h00);
    wr(5'd2, 8'hFF);
    rd_chk("R3 status write ignored", 5'd2, 8'h0C);
    wr(5'd3, 8'hFF);
    rd_chk("R3 irq write ignored", 5'd3, 8'h00);
  endtask

  task automatic t_accept_window();
    for (int i = 0; i < 8; i++) wr(5'(16 + i), 8'(8'h10 + i));
    for (int i = 0; i < 8; i++) rd_chk("R4 accept byte", 5'(16 + i), 8'(8'h10 + i));
    rd_chk("R4 window sets bit5", 5'd2, 8'h2C);
    wr(5'd24, 8'hAA);
    rd_chk("R4 addr 24 reads zero", 5'd24, 8'h00);
  endtask

  task automatic t_leave_reset();
    wr(5'd0, 8'h08);
    chk("R7 filt code", filt_code, 32'h13121110);
    chk("R7 filt mask", filt_mask, 32'h17161514);
    chk("R7 filt single", {31'h0, filt_single}, 32'h1);
    wr(5'd16, 8'h55);
    chk("R7 filt held", filt_code, 32'h13121110);
    chk("R5 tx byte 0", {24'h0, tx_frame[7:0]}, 32'h55);
  endtask

  task automatic t_tx_buffer();
    for (int i = 0; i < 13; i++) wr(5'(16 + i), 8'(8'hA0 + i));
    for (int i = 0; i < 13; i++)
      chk("R5 tx_frame byte", {24'h0, tx_frame[i*8 +: 8]}, {24'h0, 8'(8'hA0 + i)});
    rd_chk("R5 tx readback", 5'd28, 8'hAC);
    rd_chk("R5 status", 5'd2, 8'h2C);
  endtask

  task automatic t_send();
    wr(5'd4, 8'h0F);
    wr(5'd1, 8'h01);
    chk("R6 tx_start high", {31'h0, tx_start}, 32'h1);
    @(negedge clk);
    chk("R6 tx_start one cycle", {31'h0, tx_start}, 32'h0);
    rd_chk("R6 status after send", 5'd2, 8'h0C);
    chk("R12 irq on tx", {31'h0, irq}, 32'h1);
    rd_chk("R11 irq reg tx", 5'd3, 8'h02);
    chk("R11 irq after read", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_receive();
    pulse_rx(0);
    rd_chk("R8 receiving", 5'd2, 8'h1C);
    pulse_rx(1);
    pulse_rx(1);
    rd_chk("R8 stored", 5'd2, 8'h0D);
    chk("R12 irq on rx", {31'h0, irq}, 32'h1);
    rd_chk("R11 read rx", 5'd3, 8'h01);
    rd_chk("R11 rx bit returns", 5'd3, 8'h01);
    wr(5'd1, 8'h04);
    rd_chk("R9 one left", 5'd2, 8'h0D);
    wr(5'd1, 8'h04);
    rd_chk("R9 none left", 5'd2, 8'h0C);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);
    rd_chk("R9 irq reg", 5'd3, 8'h00);
  endtask

  task automatic t_overrun();
    pulse_rx(2);
    rd_chk("R10 overrun status", 5'd2, 8'h0E);
    chk("R10 overrun irq", {31'h0, irq}, 32'h1);
    wr(5'd1, 8'h08);
    rd_chk("R10 cleared status", 5'd2, 8'h0C);
    chk("R10 cleared irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_enable_and_swreset();
    wr(5'd4, 8'h00);
    pulse_rx(1);
    chk("R12 masked", {31'h0, irq}, 32'h0);
    wr(5'd4, 8'h01);
    chk("R12 enabled", {31'h0, irq}, 32'h1);
    wr(5'd4, 8'h00);
    wr(5'd0, 8'h01);
    rd_chk("R13 status", 5'd2, 8'h3C);
    rd_chk("R13 mode", 5'd0, 8'h01);
    pulse_rx(1);
    pulse_rx(2);
    rd_chk("R8 rx ignored in reset", 5'd2, 8'h3C);
    rd_chk("R13 stale rx int", 5'd3, 8'h01);
    rd_chk("R13 no messages", 5'd3, 8'h00);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_mode_bits();
    t_ro_regs();
    t_accept_window();
    t_leave_reset();
    t_tx_buffer();
    t_send();
    t_receive();
    t_overrun();
    t_enable_and_swreset();
    finish_run();
  end
endmodule